// File: doc/BRIEF.md
# Float to Integer Converter

This block turns a 36-bit single-precision floating-point word into a 36-bit two's-complement integer. A one-bit select chooses between two rounding rules for each conversion. The first drops the fraction toward zero. The second adds one half and takes the floor, so halves round upward for both signs of operand. The caller presents a word together with a one-cycle strobe. One clock later the block returns the integer, a valid pulse and an overflow flag.

The float word is a sign bit, an excess-128 exponent and a normalized fraction. A negative number is not stored as sign and magnitude: it is the two's complement of the whole positive word. The converter therefore negates the word first, works on the magnitude, and applies the sign again after rounding.

Top module: `f2i_conv`

## Requirements
- R1: The word layout is sign at bit 35, an exponent field at bits 34:27 with a bias of 128, and a fraction at bits 26:0. The value of a positive word is fraction/2^27 × 2^(exponent−128). A negative value is the 36-bit two's complement of the whole positive word. `out_int` is a 36-bit two's-complement integer.
- R2: With `round_mode`=0 the fraction is discarded toward zero. For example, 1.9 gives 1 and −1.9 gives −1.
- R3: With `round_mode`=1 the result is floor(x + 0.5). For example, 1.5 gives 2, −1.5 gives −1, −1.6 gives −2 and −2.5 gives −2.
- R4: An all-zero input word gives integer 0 with `out_ovf`=0 in both modes.
- R5: When |x| ≥ 2^35, `out_ovf` is 1 and `out_int` keeps the value it held before the conversion. This covers a magnitude exponent field of 164 or more, and also the word with only bit 35 set.
- R6: A conversion that does not overflow clears `out_ovf`.
- R7: `out_valid` equals `in_valid` delayed by one clock. `out_int` and `out_ovf` change only in the cycle after a strobe.
- R8: After reset `out_valid`, `out_int` and `out_ovf` are all 0.
- R9: Magnitudes below one half give 0 in both modes. An exact +0.5 gives 1 when rounding and an exact −0.5 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that starts a conversion of `in_word` |
| in_word | input | 36 | Floating-point operand |
| round_mode | input | 1 | 0 = truncate toward zero, 1 = floor(x + 0.5) |
| out_valid | output | 1 | High for one cycle, one clock after `in_valid` |
| out_int | output | 36 | Converted integer, two's complement |
| out_ovf | output | 1 | Last conversion was out of range |

## Verification
Several internal faults show up at the ports in the very next cycle after the strobe. A fault in the alignment shift moves the result by a power of two. A wrong half or sticky bit shifts a rounded result by one, and only at ties or just past them, and only for one sign. A missed re-negation flips the sign of a negative result. A fault in the range test shows up one of two ways. Either `out_ovf` is raised for in-range words, or a saturated result wrongly replaces the held value. The bench sweeps the exponent across the whole range from tiny values through the overflow boundary, for both signs and both modes, with fraction patterns that land on ties, just above ties and just below them. Every one of these faults is therefore reached within a few hundred conversions.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int WORD_W_DEF = 36;
  localparam int EXP_W_DEF  = 8;
  localparam int FRAC_W_DEF = 27;
  localparam int BIAS_DEF   = 128;

  typedef enum logic {
    RND_TRUNC   = 1'b0,
    RND_HALF_UP = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
  parameter int W      = f2i_pkg::WORD_W_DEF,
  parameter int EXP_W  = f2i_pkg::EXP_W_DEF,
  parameter int FRAC_W = f2i_pkg::FRAC_W_DEF
) (
  input  logic [W-1:0]      word,
  output logic              neg,
  output logic [EXP_W-1:0]  exp_f,
  output logic [FRAC_W-1:0] frac_f,
  output logic              neg_wrap
);
  logic [W-1:0] mag_word;

  // two's complement of the whole word recovers the positive encoding
  function automatic logic [W-1:0] abs_word(input logic [W-1:0] w);
    return w[W-1] ? (~w + 1'b1) : w;
  endfunction

  always_comb begin
    neg      = word[W-1];
    mag_word = abs_word(word);
    exp_f    = mag_word[W-2 -: EXP_W];
    frac_f   = mag_word[FRAC_W-1:0];
    // only the sign-only word negates onto itself
    neg_wrap = mag_word[W-1];
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int W      = f2i_pkg::WORD_W_DEF,
  parameter int EXP_W  = f2i_pkg::EXP_W_DEF,
  parameter int FRAC_W = f2i_pkg::FRAC_W_DEF,
  parameter int BIAS   = f2i_pkg::BIAS_DEF
) (
  input  logic [EXP_W-1:0]  exp_f,
  input  logic [FRAC_W-1:0] frac_f,
  output logic [W-2:0]      int_part,
  output logic              half_bit,
  output logic              sticky,
  output logic              too_big
);
  localparam int IW   = W - 1;            // integer bits of a magnitude
  localparam int FB   = FRAC_W + 1;       // fraction bits kept in fixed point
  localparam int FXW  = IW + FB;          // fixed-point width
  localparam int ZERO_K = BIAS - 1;       // exponent giving shift of zero
  localparam int OVF_E  = BIAS + IW + 1;  // first exponent at or beyond 2^IW

  logic [FXW-1:0] fixed;

  // value * 2^FB = frac * 2^(exp - BIAS + 1)
  function automatic logic [FXW-1:0] place(input logic [EXP_W-1:0] e,
                                           input logic [FRAC_W-1:0] f);
    int k;
    logic [FXW-1:0] ext;
    k   = int'(e) - ZERO_K;
    ext = FXW'(f);
    if (k >= 0) return (k >= FXW) ? '0 : (ext << k);
    else        return (-k >= FXW) ? '0 : (ext >> (-k));
  endfunction

  always_comb begin
    fixed    = place(exp_f, frac_f);
    int_part = fixed[FXW-1 -: IW];
    half_bit = fixed[FB-1];
    sticky   = |fixed[FB-2:0];
    too_big  = int'(exp_f) >= OVF_E;
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round #(
  parameter int W = f2i_pkg::WORD_W_DEF
) (
  input  logic                neg,
  input  f2i_pkg::rnd_mode_e  mode,
  input  logic [W-2:0]        int_part,
  input  logic                half_bit,
  input  logic                sticky,
  output logic                round_up,
  output logic [W-1:0]        result
);
  logic [W-1:0] mag_r;

  // floor(x+0.5): a positive value rounds up at a tie, a negative one
  // only when strictly past the tie
  function automatic logic bump(input logic n, input f2i_pkg::rnd_mode_e m,
                                input logic h, input logic s);
    return (m == f2i_pkg::RND_HALF_UP) && h && (!n || s);
  endfunction

  always_comb begin
    round_up = bump(neg, mode, half_bit, sticky);
    mag_r    = {1'b0, int_part} + W'(round_up);
    result   = neg ? (~mag_r + 1'b1) : mag_r;
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv #(
  parameter int W      = f2i_pkg::WORD_W_DEF,
  parameter int EXP_W  = f2i_pkg::EXP_W_DEF,
  parameter int FRAC_W = f2i_pkg::FRAC_W_DEF,
  parameter int BIAS   = f2i_pkg::BIAS_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  input  logic         round_mode,
  output logic         out_valid,
  output logic [W-1:0] out_int,
  output logic         out_ovf
);
  logic              neg, neg_wrap, half_bit, sticky, too_big, round_up;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [W-2:0]      int_part;
  logic [W-1:0]      conv_res;
  logic              ovf_det;
  f2i_pkg::rnd_mode_e mode;

  assign mode    = f2i_pkg::rnd_mode_e'(round_mode);
  assign ovf_det = too_big | neg_wrap;

  f2i_unpack #(.W(W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .word(in_word), .neg(neg), .exp_f(exp_f), .frac_f(frac_f),
    .neg_wrap(neg_wrap)
  );

  f2i_align #(.W(W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) u_align (
    .exp_f(exp_f), .frac_f(frac_f), .int_part(int_part),
    .half_bit(half_bit), .sticky(sticky), .too_big(too_big)
  );

  f2i_round #(.W(W)) u_round (
    .neg(neg), .mode(mode), .int_part(int_part), .half_bit(half_bit),
    .sticky(sticky), .round_up(round_up), .result(conv_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_int   <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ovf <= ovf_det;
        if (!ovf_det) out_int <= conv_res;
      end
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_int) && $stable(out_ovf)));
  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf_det) |=> (out_ovf && $stable(out_int)));
  // R6
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovf_det) |=> !out_ovf);
  // R4
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word == '0) |=> (out_int == '0 && !out_ovf));
  // R2
  trunc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_word[W-1] && !round_mode && !ovf_det) |=> !out_int[W-1]);
  // R3
  round_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_word[W-1] && round_up) |=> (out_int != '0 && !out_int[W-1]));
endmodule

// File: tb/sim_f2i_conv.sv
module sim_f2i_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [35:0] in_word = '0;
  logic        round_mode = 1'b0;
  logic        out_valid;
  logic [35:0] out_int;
  logic        out_ovf;

  int n_chk = 0;
  int n_bad = 0;
  logic [35:0] last_int = '0;
  bit done = 0;

  always #2 clk = ~clk;

  f2i_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .round_mode(round_mode), .out_valid(out_valid), .out_int(out_int),
    .out_ovf(out_ovf)
  );

  task automatic check(input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R1: build a word from sign, exponent and fraction
  function automatic logic [35:0] mk(input bit ng, input int e, input int f);
    logic [35:0] w;
    w = {1'b0, 8'(e), 27'(f)};
    return ng ? (~w + 36'd1) : w;
  endfunction

  // remainder-compare model of both rounding rules
  task automatic model(input bit ng, input int e, input int f, input bit rm,
                       output logic [35:0] ei, output bit eo);
    int sh;
    longint q, rem, mag;
    int cmp;
    sh = 155 - e;
    eo = 0;
    if (sh <= 0) begin
      mag = longint'(f) << (-sh);
      q = mag; cmp = -1;
      eo = (mag >= (64'sd1 <<< 35));
    end else if (sh >= 40) begin
      q = 0; cmp = -1;
    end else begin
      q = longint'(f) >>> sh;
      rem = longint'(f) - (q <<< sh);
      cmp = (2*rem > (64'sd1 <<< sh)) ? 1 : ((2*rem == (64'sd1 <<< sh)) ? 0 : -1);
    end
    if (rm) q = q + ((ng ? (cmp > 0) : (cmp >= 0)) ? 1 : 0);
    ei = ng ? 36'(-q) : 36'(q);
  endtask

  task automatic convert(input logic [35:0] w, input bit rm,
                         input logic [35:0] ei, input bit eo, input string req);
    @(negedge clk);
    in_word = w; round_mode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R7 valid"}, 36'(out_valid), 36'd1);
    check({req, " R5/R6 ovf"}, 36'(out_ovf), 36'(eo));
    if (eo) check({req, " R5 held"}, out_int, last_int);
    else begin
      check({req, " result"}, out_int, ei);
      last_int = ei;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] ei;
    bit eo;
    int fr[6];
    fr[0] = 1 << 26; fr[1] = (1 << 26) + 1; fr[2] = 3 << 25;
    fr[3] = (3 << 25) + 1; fr[4] = (1 << 27) - 1; fr[5] = 32'h5555555 | (1 << 26);
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 valid", 36'(out_valid), 36'd0);
    check("R8 int", out_int, 36'd0);
    check("R8 ovf", 36'(out_ovf), 36'd0);
    rst_n = 1'b1;

    // R4 zero in both modes
    convert(36'd0, 1'b0, 36'd0, 1'b0, "R4 trunc");
    convert(36'd0, 1'b1, 36'd0, 1'b0, "R4 round");
    // R2 truncation
    convert(mk(0, 129, 127506841), 1'b0, 36'd1, 1'b0, "R2 +1.9");
    convert(mk(1, 129, 127506841), 1'b0, 36'hFFFFFFFFF, 1'b0, "R2 -1.9");
    // R3 floor(x+0.5)
    convert(mk(0, 129, 3 << 25), 1'b1, 36'd2, 1'b0, "R3 +1.5");
    convert(mk(1, 129, 3 << 25), 1'b1, 36'hFFFFFFFFF, 1'b0, "R3 -1.5");
    convert(mk(1, 129, 107374182), 1'b1, 36'hFFFFFFFFE, 1'b0, "R3 -1.6");
    convert(mk(1, 130, 5 << 24), 1'b1, 36'hFFFFFFFFE, 1'b0, "R3 -2.5");
    // R9 halves and tiny values
    convert(mk(0, 128, 1 << 26), 1'b1, 36'd1, 1'b0, "R9 +0.5");
    convert(mk(1, 128, 1 << 26), 1'b1, 36'd0, 1'b0, "R9 -0.5");
    convert(mk(1, 127, 3 << 25), 1'b0, 36'd0, 1'b0, "R9 -0.375");
    // R5 overflow holds, R6 clears
    convert(mk(0, 131, 1 << 26), 1'b0, 36'd4, 1'b0, "R6 setup");
    convert(mk(0, 164, 1 << 26), 1'b0, 36'd0, 1'b1, "R5 2^35");
    convert(36'h800000000, 1'b1, 36'd0, 1'b1, "R5 sign-only");
    convert(mk(0, 163, (1 << 27) - 1), 1'b0, 36'h7FFFFFF00, 1'b0, "R6 max");
    // R7 idle cycle: no strobe, outputs stay
    @(negedge clk);
    in_word = mk(1, 140, 1 << 26);
    @(negedge clk);
    check("R7 idle valid", 36'(out_valid), 36'd0);
    check("R7 idle int", out_int, last_int);
    check("R7 idle ovf", 36'(out_ovf), 36'd0);

    // R1 sweep over exponent, fraction, sign and mode
    for (int e = 100; e <= 170; e++)
      for (int k = 0; k < 6; k++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 2; m++) begin
            model(s[0], e, fr[k], m[0], ei, eo);
            convert(mk(s[0], e, fr[k]), m[0], ei, eo, m ? "R1 R3 sweep" : "R1 R2 sweep");
          end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule